// File: doc/BRIEF.md
# Local Bus Memory Slave Target

This block is the slave side of a synchronous 32-bit processor local bus. It samples an active-low address strobe along with a 3-bit cycle-type code, a word address and four active-low byte enables. When the cycle is a memory-space access whose address falls inside the block's window, the target claims it. It then reads or writes a small internal word array, one byte lane at a time, and completes the transfer with a ready strobe. A master that also asserts its burst request with the strobe receives four data phases. Each phase is paced by a beat-ready strobe, and the word address steps through an aligned four-word group with wrap-around.

The master cannot stall the target. The target alone sets the pace: a parameter fixes the number of wait cycles between the claim and the first ready, and the master must hold write data stable and take read data in each cycle that carries a ready strobe. Cycles outside the window, I/O cycles, interrupt-acknowledge and special cycles leave every output inactive. A build-time option makes the target report a 16-bit transfer width for as long as it claims a cycle.

Top module: `lb_target`

## Requirements
- R1: The cycle type is `cyc_type = {memory_not_io, data_not_command, write_not_read}`. The codes 3'b110 (memory read), 3'b111 (memory write) and 3'b100 (instruction fetch, treated as a read) are memory-space codes. A strobe sampled low with a memory-space code and a word address inside [BASE_ADDR, BASE_ADDR + 4*DEPTH_WORDS) drives `claim_n` low from the next cycle until the cycle after the final ready.
- R2: A strobe with any other code (3'b000 interrupt acknowledge, 3'b010 I/O read, 3'b011 I/O write, 3'b001, 3'b101), or with an address outside the window, causes no claim and no ready, and leaves the array unchanged.
- R3: The first ready strobe comes exactly WAITS (0 to 3) claimed cycles after `claim_n` first goes low.
- R4: A claimed cycle without a burst request completes with `single_rdy_n` low for exactly one cycle. `burst_rdy_n` stays high, and the two ready outputs are never low together.
- R5: A claimed cycle with `burst_req_n` low at the strobe completes with `burst_rdy_n` low in four consecutive cycles while `single_rdy_n` stays high. Beat k uses word index {index[IDX_W-1:2], index[1:0]+k}, so the beats wrap inside an aligned 16-byte group.
- R6: `byte_en_n[i]` low enables lane i, which is data bits [8i+7:8i]. A write updates only the enabled lanes of the addressed word.
- R7: `rd_oe` is high, and `rd_data` carries the addressed word, only in read cycles that carry a ready strobe. At all other times `rd_oe` is low and `rd_data` is zero.
- R8: With NARROW=1, `size16_n` is low in every cycle in which `claim_n` is low. With NARROW=0 it is always high.
- R9: While `rst_n` is sampled low, synchronous to `clk`, the target aborts any cycle in progress and clears the array to zero. In the cycle after reset, `claim_n`, `single_rdy_n`, `burst_rdy_n` and `size16_n` are high and `rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strobe_n | input | 1 | Active-low address strobe, one cycle per transfer |
| cyc_type | input | 3 | {memory_not_io, data_not_command, write_not_read} |
| word_addr | input | 30 | Byte address bits 31..2 |
| byte_en_n | input | 4 | Active-low lane enables |
| burst_req_n | input | 1 | Active-low four-beat burst request, sampled with the strobe |
| wr_data | input | 32 | Write data, sampled in each ready cycle of a write |
| claim_n | output | 1 | Active-low claim of the current cycle |
| single_rdy_n | output | 1 | Active-low completion of a single transfer |
| burst_rdy_n | output | 1 | Active-low completion of one burst beat |
| size16_n | output | 1 | Active-low 16-bit width report |
| rd_data | output | 32 | Read data, zero when not driven |
| rd_oe | output | 1 | Read data drive enable |

## Verification
The bound checker checks the following on every cycle: a claim starts only in the cycle after a strobe, ready strobes occur only inside a claim and never together, the first ready arrives after the configured wait count, a claim ends after one or four beats, the data enable is tied to a ready strobe, and all outputs are inactive after reset. Only the bench's scenarios can show the data-side behaviour: window and cycle-type decoding, lane-selective writes, wrap-around word order in bursts, arrays left untouched by ignored cycles, the width report of the narrow variant, and memory clearing by a reset that lands mid-cycle.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } lb_state_e;

  // {memory_not_io, data_not_command, write_not_read}
  localparam logic [2:0] CYC_MEM_RD = 3'b110;
  localparam logic [2:0] CYC_MEM_WR = 3'b111;
  localparam logic [2:0] CYC_FETCH  = 3'b100;

  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

endpackage

// File: rtl/lb_decode.sv
module lb_decode #(
  parameter int          AW      = 30,
  parameter int          IDX_W   = 4,
  parameter logic [29:0] BASE_WORD = 30'h0
) (
  input  logic [2:0]    cyc_type,
  input  logic [AW-1:0] word_addr,
  output logic          hit,
  output logic          is_write
);
  import lb_pkg::*;

  logic mem_space;
  logic in_window;

  always_comb begin
    mem_space = (cyc_type == CYC_MEM_RD) || (cyc_type == CYC_MEM_WR) ||
                (cyc_type == CYC_FETCH);
    in_window = (word_addr[AW-1:IDX_W] == BASE_WORD[AW-1:IDX_W]);
    hit       = mem_space && in_window;
    is_write  = (cyc_type == CYC_MEM_WR);
  end

endmodule

// File: rtl/lb_seq.sv
module lb_seq #(
  parameter int IDX_W = 4,
  parameter int WAITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             start_write,
  input  logic             start_burst,
  input  logic [3:0]       start_be_n,
  output logic             claim,
  output logic             single_rdy,
  output logic             burst_rdy,
  output logic             wr_en,
  output logic             rd_beat,
  output logic [IDX_W-1:0] beat_idx,
  output logic [3:0]       lane_en
);
  import lb_pkg::*;

  localparam logic [1:0] WAIT_LOAD = 2'(WAITS);

  lb_state_e        state;
  logic [1:0]       wcnt;
  logic [1:0]       beat;
  logic             burst_q;
  logic             write_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       be_n_q;
  logic [1:0]       low_idx;
  logic             xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      beat    <= '0;
      burst_q <= 1'b0;
      write_q <= 1'b0;
      idx_q   <= '0;
      be_n_q  <= 4'hF;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            idx_q   <= start_idx;
            write_q <= start_write;
            burst_q <= start_burst;
            be_n_q  <= start_be_n;
            beat    <= '0;
            wcnt    <= WAIT_LOAD;
            state   <= (WAITS == 0) ? ST_XFER : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wcnt == 2'd1) state <= ST_XFER;
          wcnt <= wcnt - 2'd1;
        end
        ST_XFER: begin
          if (burst_q && (beat != 2'd3)) beat <= beat + 2'd1;
          else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    xfer       = (state == ST_XFER);
    claim      = (state != ST_IDLE);
    single_rdy = xfer && !burst_q;
    burst_rdy  = xfer && burst_q;
    wr_en      = xfer && write_q;
    rd_beat    = xfer && !write_q;
    low_idx    = idx_q[1:0] + beat;
    beat_idx   = {idx_q[IDX_W-1:2], low_idx};
    lane_en    = ~be_n_q;
  end

endmodule

// File: rtl/lb_store.sv
module lb_store #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       lane_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] bytes [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bytes[i] <= '0;
      end else if (wr_en && lane_en[l]) begin
        bytes[idx] <= wdata[8*l +: 8];
      end
    end

    assign rdata[8*l +: 8] = bytes[idx];
  end

endmodule

// File: rtl/lb_target.sv
module lb_target #(
  parameter logic [31:0] BASE_ADDR   = 32'h0000_4000,
  parameter int          DEPTH_WORDS = 16,
  parameter int          WAITS       = 2,
  parameter bit          NARROW      = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_strobe_n,
  input  logic [2:0]  cyc_type,
  input  logic [29:0] word_addr,
  input  logic [3:0]  byte_en_n,
  input  logic        burst_req_n,
  input  logic [31:0] wr_data,
  output logic        claim_n,
  output logic        single_rdy_n,
  output logic        burst_rdy_n,
  output logic        size16_n,
  output logic [31:0] rd_data,
  output logic        rd_oe
);

  localparam int          IDX_W     = $clog2(DEPTH_WORDS);
  localparam logic [29:0] BASE_WORD = BASE_ADDR[31:2];

  logic             hit;
  logic             is_write;
  logic             claim;
  logic             single_rdy;
  logic             burst_rdy;
  logic             wr_en;
  logic             rd_beat;
  logic [IDX_W-1:0] beat_idx;
  logic [3:0]       lane_en;
  logic [31:0]      mem_rdata;

  lb_decode #(
    .AW       (30),
    .IDX_W    (IDX_W),
    .BASE_WORD(BASE_WORD)
  ) u_decode (
    .cyc_type (cyc_type),
    .word_addr(word_addr),
    .hit      (hit),
    .is_write (is_write)
  );

  lb_seq #(
    .IDX_W(IDX_W),
    .WAITS(WAITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (!addr_strobe_n && hit),
    .start_idx  (word_addr[IDX_W-1:0]),
    .start_write(is_write),
    .start_burst(!burst_req_n),
    .start_be_n (byte_en_n),
    .claim      (claim),
    .single_rdy (single_rdy),
    .burst_rdy  (burst_rdy),
    .wr_en      (wr_en),
    .rd_beat    (rd_beat),
    .beat_idx   (beat_idx),
    .lane_en    (lane_en)
  );

  lb_store #(
    .DEPTH(DEPTH_WORDS),
    .IDX_W(IDX_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .idx    (beat_idx),
    .lane_en(lane_en),
    .wdata  (wr_data),
    .rdata  (mem_rdata)
  );

  always_comb begin
    claim_n      = !claim;
    single_rdy_n = !single_rdy;
    burst_rdy_n  = !burst_rdy;
    size16_n     = NARROW ? !claim : 1'b1;
    rd_oe        = rd_beat;
    rd_data      = rd_beat ? mem_rdata : '0;
  end

endmodule

// File: rtl/lb_target_chk.sv
module lb_target_chk #(
  parameter int WAITS  = 2,
  parameter bit NARROW = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic addr_strobe_n,
  input logic claim_n,
  input logic single_rdy_n,
  input logic burst_rdy_n,
  input logic size16_n,
  input logic rd_oe
);

  logic       past_rst;
  logic       seen_rdy;
  logic [2:0] lat_cnt;
  logic [2:0] beat_cnt;
  logic       any_rdy;

  assign any_rdy = !single_rdy_n || !burst_rdy_n;

  always_ff @(posedge clk) begin
    past_rst <= !rst_n;
    if (!rst_n || claim_n) begin
      seen_rdy <= 1'b0;
      lat_cnt  <= '0;
      beat_cnt <= '0;
    end else begin
      if (!seen_rdy) begin
        if (any_rdy) seen_rdy <= 1'b1;
        else lat_cnt <= lat_cnt + 3'd1;
      end
      if (!burst_rdy_n) beat_cnt <= beat_cnt + 3'd1;
    end
  end

  // R1: a claim begins only in the cycle after a strobe
  a_r1_claim_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(claim_n) |-> $past(!addr_strobe_n));

  // R1: ready strobes only inside a claim
  a_r1_ready_inside_claim: assert property (@(posedge clk) disable iff (!rst_n)
    any_rdy |-> !claim_n);

  // R4: the two ready outputs are exclusive
  a_r4_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!single_rdy_n && !burst_rdy_n));

  // R4: a single transfer ends right after its ready
  a_r4_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
    !single_rdy_n |=> claim_n);

  // R3: the first ready comes after the configured wait count
  a_r3_wait_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_n && !seen_rdy && any_rdy) |-> (lat_cnt == 3'(WAITS)));

  // R5: a claim ends after no beats (single) or exactly four beats
  a_r5_beat_total: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim_n) |-> (beat_cnt == 3'd0 || beat_cnt == 3'd4));

  // R7: read data enable only with a ready strobe
  a_r7_oe_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> any_rdy);

  // R9: everything inactive after a reset edge
  always @(posedge clk) begin
    if (past_rst === 1'b1) begin
      a_r9_idle_after_reset: assert (claim_n && single_rdy_n && burst_rdy_n &&
                                     size16_n && !rd_oe)
        else $error("R9 outputs active after reset");
    end
  end

endmodule

bind lb_target lb_target_chk #(
  .WAITS (WAITS),
  .NARROW(NARROW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_strobe_n(addr_strobe_n),
  .claim_n      (claim_n),
  .single_rdy_n (single_rdy_n),
  .burst_rdy_n  (burst_rdy_n),
  .size16_n     (size16_n),
  .rd_oe        (rd_oe)
);

// File: tb/test_lb_target.sv
`timescale 1ns/1ps
module test_lb_target;

  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam int A_WAITS = 2;
  localparam int NVEC = 19;

  // {cyc_type[3], burst[1], byte address[32], byte_en_n[4], write data[32]}
  localparam logic [71:0] VECS [NVEC] = '{
    {3'b110, 1'b0, 32'h0000_4014, 4'h0, 32'h0000_0000},
    {3'b111, 1'b0, 32'h0000_4000, 4'h0, 32'h1122_3344},
    {3'b111, 1'b0, 32'h0000_4004, 4'h0, 32'hA5A5_A5A5},
    {3'b110, 1'b0, 32'h0000_4000, 4'h0, 32'h0000_0000},
    {3'b111, 1'b0, 32'h0000_4008, 4'hC, 32'hDEAD_BEEF},
    {3'b110, 1'b0, 32'h0000_4008, 4'h0, 32'h0000_0000},
    {3'b111, 1'b0, 32'h0000_4040, 4'h0, 32'hFFFF_FFFF},
    {3'b011, 1'b0, 32'h0000_4004, 4'h0, 32'h0000_0000},
    {3'b100, 1'b0, 32'h0000_4004, 4'h0, 32'h0000_0000},
    {3'b111, 1'b0, 32'h0000_400C, 4'h0, 32'h0123_4567},
    {3'b110, 1'b1, 32'h0000_4008, 4'h0, 32'h0000_0000},
    {3'b000, 1'b0, 32'h0000_4000, 4'h0, 32'h0000_0000},
    {3'b111, 1'b0, 32'h0000_403C, 4'h7, 32'hAB00_0000},
    {3'b110, 1'b0, 32'h0000_403C, 4'h0, 32'h0000_0000},
    {3'b110, 1'b1, 32'h0000_403C, 4'h0, 32'h0000_0000},
    {3'b010, 1'b0, 32'h0000_4000, 4'h0, 32'h0000_0000},
    {3'b110, 1'b0, 32'h0000_3FFC, 4'h0, 32'h0000_0000},
    {3'b111, 1'b0, 32'h0000_4000, 4'hA, 32'h00FF_00FF},
    {3'b110, 1'b0, 32'h0000_4000, 4'h0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_strobe_n = 1'b1;
  logic [2:0]  cyc_type = 3'b000;
  logic [29:0] word_addr = '0;
  logic [3:0]  byte_en_n = 4'hF;
  logic        burst_req_n = 1'b1;
  logic [31:0] wr_data = '0;

  logic a_claim_n, a_srdy_n, a_brdy_n, a_sz_n, a_oe;
  logic b_claim_n, b_srdy_n, b_brdy_n, b_sz_n, b_oe;
  logic [31:0] a_rd, b_rd;

  always #2.5 clk = ~clk;

  lb_target i_lb_target (
    .clk(clk), .rst_n(rst_n), .addr_strobe_n(addr_strobe_n), .cyc_type(cyc_type),
    .word_addr(word_addr), .byte_en_n(byte_en_n), .burst_req_n(burst_req_n),
    .wr_data(wr_data), .claim_n(a_claim_n), .single_rdy_n(a_srdy_n),
    .burst_rdy_n(a_brdy_n), .size16_n(a_sz_n), .rd_data(a_rd), .rd_oe(a_oe));

  lb_target #(.WAITS(0), .NARROW(1'b1)) i_lb_target_n16 (
    .clk(clk), .rst_n(rst_n), .addr_strobe_n(addr_strobe_n), .cyc_type(cyc_type),
    .word_addr(word_addr), .byte_en_n(byte_en_n), .burst_req_n(burst_req_n),
    .wr_data(wr_data), .claim_n(b_claim_n), .single_rdy_n(b_srdy_n),
    .burst_rdy_n(b_brdy_n), .size16_n(b_sz_n), .rd_data(b_rd), .rd_oe(b_oe));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] ref_mem [16];

  // per-cycle observations
  bit a_claimed, a_seen, b_claimed, b_seen, oe_bad, sz_bad;
  int a_lat, a_ns, a_nb, b_lat, b_nb, b_ns;
  logic [31:0] a_words [4];
  logic [31:0] b_words [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] ben);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{~ben[i]}};
    return m;
  endfunction

  task automatic run_cycle(input logic [2:0] ct, input bit bst, input logic [31:0] addr,
                           input logic [3:0] ben, input logic [31:0] wd);
    a_claimed = 0; a_seen = 0; a_lat = 0; a_ns = 0; a_nb = 0;
    b_claimed = 0; b_seen = 0; b_lat = 0; b_ns = 0; b_nb = 0;
    oe_bad = 0; sz_bad = 0;
    @(posedge clk); #1;
    addr_strobe_n = 1'b0; cyc_type = ct; word_addr = addr[31:2];
    byte_en_n = ben; burst_req_n = !bst; wr_data = wd;
    @(posedge clk); #1;
    addr_strobe_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (!a_claim_n) begin
        a_claimed = 1;
        if (!a_srdy_n || !a_brdy_n) begin
          if (a_ns + a_nb < 4) a_words[a_ns + a_nb] = a_rd;
          a_seen = 1;
          if (!a_srdy_n) a_ns++;
          if (!a_brdy_n) a_nb++;
        end else if (!a_seen) a_lat++;
      end else if (!a_srdy_n || !a_brdy_n) a_ns += 10;
      if (!b_claim_n) begin
        b_claimed = 1;
        if (b_sz_n) sz_bad = 1;
        if (!b_srdy_n || !b_brdy_n) begin
          if (b_ns + b_nb < 4) b_words[b_ns + b_nb] = b_rd;
          b_seen = 1;
          if (!b_srdy_n) b_ns++;
          if (!b_brdy_n) b_nb++;
        end else if (!b_seen) b_lat++;
      end else if (!b_sz_n) sz_bad = 1;
      if (!a_sz_n) sz_bad = 1;
      if (!a_oe && a_rd != 32'h0) oe_bad = 1;
      if (a_oe && a_srdy_n && a_brdy_n) oe_bad = 1;
      if (a_oe && ct == 3'b111) oe_bad = 1;
      if (!a_oe && ct != 3'b111 && (!a_srdy_n || !a_brdy_n)) oe_bad = 1;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [71:0] e;
    logic [2:0]  ct;
    logic        bst;
    logic [31:0] addr, wd, m, expw;
    logic [3:0]  ben, wi, w;
    bit          exp_claim;

    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: outputs inactive during reset
    check(a_claim_n && a_srdy_n && a_brdy_n && a_sz_n && !a_oe && b_sz_n,
          "R9", "reset outputs", {27'h0, a_claim_n, a_srdy_n, a_brdy_n, a_sz_n, a_oe},
          32'h0000_001E);
    @(posedge clk); #1 rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      e = VECS[v];
      ct = e[71:69]; bst = e[68]; addr = e[67:36]; ben = e[35:32]; wd = e[31:0];
      wi = addr[5:2];
      exp_claim = (ct == 3'b110 || ct == 3'b111 || ct == 3'b100) &&
                  (addr[31:6] == BASE[31:6]);
      run_cycle(ct, bst, addr, ben, wd);
      check(a_claimed == exp_claim, exp_claim ? "R1" : "R2", "claim",
            32'(a_claimed), 32'(exp_claim));
      check(b_claimed == exp_claim, exp_claim ? "R1" : "R2", "claim narrow",
            32'(b_claimed), 32'(exp_claim));
      check(!oe_bad, "R7", "data enable", 32'(oe_bad), 32'h0);
      check(!sz_bad, "R8", "size report", 32'(sz_bad), 32'h0);
      if (!exp_claim) begin
        check(a_ns + a_nb == 0, "R2", "ready on ignored cycle", 32'(a_ns + a_nb), 32'h0);
      end else begin
        check(a_lat == A_WAITS, "R3", "wait cycles", 32'(a_lat), 32'(A_WAITS));
        check(b_lat == 0, "R3", "wait cycles zero", 32'(b_lat), 32'h0);
        if (bst) begin
          check(a_nb == 4 && a_ns == 0, "R5", "burst beats", 32'(a_nb * 16 + a_ns), 32'h40);
          check(b_nb == 4 && b_ns == 0, "R5", "burst beats narrow", 32'(b_nb * 16 + b_ns), 32'h40);
        end else begin
          check(a_ns == 1 && a_nb == 0, "R4", "single ready", 32'(a_ns * 16 + a_nb), 32'h10);
          check(b_ns == 1 && b_nb == 0, "R4", "single ready narrow", 32'(b_ns * 16 + b_nb), 32'h10);
        end
        m = lane_mask(ben);
        if (ct == 3'b111) begin
          ref_mem[wi] = (ref_mem[wi] & ~m) | (wd & m);
        end else begin
          for (int k = 0; k < (bst ? 4 : 1); k++) begin
            w = {wi[3:2], wi[1:0] + 2'(k)};
            expw = ref_mem[w];
            check((a_words[k] & m) == (expw & m), bst ? "R5" : "R6", "read word",
                  a_words[k], expw);
            check((b_words[k] & m) == (expw & m), "R1", "read word narrow",
                  b_words[k], expw);
          end
        end
      end
    end

    // R9: reset during the wait phase of a write aborts it and clears the array
    @(posedge clk); #1;
    addr_strobe_n = 1'b0; cyc_type = 3'b111; word_addr = 30'h0000_1004;
    byte_en_n = 4'h0; burst_req_n = 1'b1; wr_data = 32'hCAFE_F00D;
    @(posedge clk); #1 addr_strobe_n = 1'b1;
    @(negedge clk);
    check(!a_claim_n, "R9", "claim before reset", 32'(a_claim_n), 32'h0);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(a_claim_n && a_srdy_n && a_brdy_n && !a_oe && b_sz_n, "R9", "idle after abort",
          {28'h0, a_claim_n, a_srdy_n, a_brdy_n, a_oe}, 32'h0000_000E);
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    run_cycle(3'b110, 1'b0, 32'h0000_4000, 4'h0, 32'h0);
    check(a_words[0] == 32'h0, "R9", "array cleared", a_words[0], 32'h0);
    check(b_words[0] == 32'h0, "R9", "array cleared narrow", b_words[0], 32'h0);
    run_cycle(3'b110, 1'b0, 32'h0000_4010, 4'h0, 32'h0);
    check(a_words[0] == 32'h0, "R9", "aborted write left no data", a_words[0], 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule